// File: doc/BRIEF.md
# Interval Timer with Toggle Output

This block is a 16-bit down-counting interval timer for a peripheral port controller. Software programs a 16-bit reload latch one byte at a time over a byte-wide register bus. A write to the counter's upper byte copies the latch into the counter and starts it. From then on the counter counts down by one on every clock. When it passes below zero, the timer raises an interrupt flag. In free-running mode the counter then reloads from the latch. In one-shot mode it keeps wrapping down silently and raises no further flags until it is started again.

The timer can also produce a square wave on bit 7 of an 8-bit output port. This wave bit is held in the timer's own storage and does not change the port's programmed output bit. It takes over the pin only while wave mode is selected. While it is in charge, it also forces the pin to drive and replaces the value a port read returns for that bit. A control register holds the mode bits.

Register addresses on `bus_addr`:

| Address | Read returns | Write does |
|---|---|---|
| 0 | counter low byte | sets latch low byte |
| 1 | counter high byte | sets latch high byte and starts the counter |
| 2 | latch low byte | sets latch low byte |
| 3 | latch high byte | sets latch high byte without starting |
| 4 | control register | sets control register |

Other addresses read as zero. Control bit 6 selects free-running mode and control bit 7 selects wave mode.

Top module: `itmr_top`

## Requirements
- R1: After reset the counter holds still at 0x0000 until it is first started. The latch and the control register read 0x00, `irq` is low and the wave bit is high.
- R2: A write to address 0 or address 2 changes only the latch low byte (read back at address 2). It neither starts nor changes the counter.
- R3: A write to address 3 stores the latch high byte and clears `irq`. It does not load or start the counter.
- R4: A write to address 1 stores the latch high byte, loads the counter with the full latch value ({written byte, latch low}) on that clock edge, starts it and clears `irq`.
- R5: A running counter decrements once per clock. For a loaded value N, `irq` rises on the (N+1)th clock edge after the loading edge, which is the edge on which the counter passes from 0x0000 past zero.
- R6: In one-shot mode (control bit 6 = 0) the counter wraps to 0xFFFF and keeps counting, but `irq` is set at most once for each start, even across a full wrap.
- R7: In free-running mode (control bit 6 = 1) the counter reloads from the latch as it passes zero, so `irq` is set every N+1 clocks.
- R8: A read of address 0 clears `irq`. Reads of addresses 1, 2 and 3 leave it unchanged.
- R9: In wave mode (control bit 7 = 1) a start drives the wave bit low, and each expiry that sets `irq` inverts it.
- R10: A control write with bit 7 = 0 sets the wave bit high. A later switch into wave mode therefore starts the pin at high.
- R11: In wave mode `pin_oe` is 1, `pin_val` equals the wave bit and `port_rd_bit` returns the wave bit. Otherwise `pin_val`/`pin_oe` follow `prog_bit`/`prog_dir`, and `port_rd_bit` is `prog_bit` when `prog_dir` = 1 and `pin_in` when `prog_dir` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (read side effects) |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| irq | output | 1 | Timer interrupt flag |
| prog_bit | input | 1 | Port output register bit 7 |
| prog_dir | input | 1 | Port direction bit 7 (1 = output) |
| pin_in | input | 1 | Sensed level of the bit 7 pin |
| pin_val | output | 1 | Value driven onto the bit 7 pin |
| pin_oe | output | 1 | Drive enable for the bit 7 pin |
| port_rd_bit | output | 1 | Bit 7 of a port read |

## Verification
The bench counts clock edges from each start and checks that `irq` is still low one cycle before the N+1 boundary and high exactly on it. A design that is off by one in reload or underflow detection misses one of those two samples. After a one-shot expiry, the bench waits through a whole 65536-cycle wrap of the counter. A design that does not disarm would raise a second flag there. The bench reads all three non-clearing addresses with the flag set, and checks that writing the latch high byte leaves the counter alone. It also follows the wave bit through a start, two expiries, a mode exit and a re-entry. A design that shares the bit with the programmed port value, or that does not reset it to high on exit, gives the wrong pin level at one of these steps.

// File: rtl/itmr_pkg.sv
package itmr_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 16;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_CNT_LO = 3'd0;
  localparam logic [ADDR_W-1:0] A_CNT_HI = 3'd1;
  localparam logic [ADDR_W-1:0] A_LAT_LO = 3'd2;
  localparam logic [ADDR_W-1:0] A_LAT_HI = 3'd3;
  localparam logic [ADDR_W-1:0] A_CTL    = 3'd4;

  localparam int CTL_FREE = 6;
  localparam int CTL_WAVE = 7;

  typedef struct packed {
    logic lat_lo_we;
    logic lat_hi_we;
    logic start_we;
    logic ctl_we;
    logic cnt_lo_rd;
  } itmr_strobe_t;
endpackage

// File: rtl/itmr_decode.sv
module itmr_decode
  import itmr_pkg::*;
#(
  parameter int CW = CNT_W,
  parameter int BW = BYTE_W
) (
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CW-1:0]     cnt,
  input  logic [CW-1:0]     lat,
  input  logic [BW-1:0]     ctl,
  output itmr_strobe_t      stb,
  output logic [BW-1:0]     rdata
);
  always_comb begin
    stb = '0;
    if (bus_wr) begin
      case (bus_addr)
        A_CNT_LO, A_LAT_LO: stb.lat_lo_we = 1'b1;
        A_CNT_HI:           stb.start_we  = 1'b1;
        A_LAT_HI:           stb.lat_hi_we = 1'b1;
        A_CTL:              stb.ctl_we    = 1'b1;
        default: ;
      endcase
    end
    if (bus_rd && bus_addr == A_CNT_LO) stb.cnt_lo_rd = 1'b1;
  end

  always_comb begin
    case (bus_addr)
      A_CNT_LO: rdata = cnt[BW-1:0];
      A_CNT_HI: rdata = cnt[CW-1:BW];
      A_LAT_LO: rdata = lat[BW-1:0];
      A_LAT_HI: rdata = lat[CW-1:BW];
      A_CTL:    rdata = ctl;
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/itmr_latch.sv
module itmr_latch
  import itmr_pkg::*;
#(
  parameter int CW = CNT_W,
  parameter int BW = BYTE_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          lo_we,
  input  logic          hi_we,
  input  logic [BW-1:0] wdata,
  output logic [CW-1:0] lat,
  output logic [CW-1:0] ld_val
);
  localparam int HW = CW - BW;

  logic [BW-1:0] lo_q, lo_d;
  logic [HW-1:0] hi_q, hi_d;

  always_comb begin
    lo_d = lo_q;
    hi_d = hi_q;
    if (lo_we) lo_d = wdata;
    if (hi_we) hi_d = wdata[HW-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      if (lo_we) lo_q <= lo_d;
      if (hi_we) hi_q <= hi_d;
    end
  end

  assign lat    = {hi_q, lo_q};
  assign ld_val = {wdata[HW-1:0], lo_q};

  // R2: a low-byte write leaves the upper byte alone
  assert_lo_only_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lo_we && !hi_we) |=> (lo_q == $past(wdata) && hi_q == $past(hi_q)))
    else $error("low write disturbed latch");
endmodule

// File: rtl/itmr_count.sv
module itmr_count
  import itmr_pkg::*;
#(
  parameter int CW = CNT_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load,
  input  logic [CW-1:0] ld_val,
  input  logic [CW-1:0] reload_val,
  input  logic          free_run,
  input  logic          clr,
  output logic [CW-1:0] cnt,
  output logic          flag,
  output logic          expire
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          run_q, run_d;
  logic          arm_q, arm_d;
  logic          flg_q, flg_d;
  logic          uflow;

  assign uflow  = run_q && (cnt_q == '0) && !load;
  assign expire = uflow && arm_q;

  always_comb begin
    cnt_d = cnt_q;
    run_d = run_q | load;
    arm_d = arm_q;
    flg_d = flg_q;
    if (load) begin
      cnt_d = ld_val;
      arm_d = 1'b1;
    end else if (run_q) begin
      cnt_d = (uflow && free_run) ? reload_val : cnt_q - 1'b1;
    end
    if (expire && !free_run) arm_d = 1'b0;
    if (load)        flg_d = 1'b0;
    else if (expire) flg_d = 1'b1;
    else if (clr)    flg_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
      arm_q <= 1'b0;
      flg_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      run_q <= run_d;
      arm_q <= arm_d;
      flg_q <= flg_d;
    end
  end

  assign cnt  = cnt_q;
  assign flag = flg_q;

  assert_start_load_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load |=> (cnt_q == $past(ld_val) && !flg_q && run_q))
    else $error("start did not load");

  assert_flag_on_uflow_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && arm_q && cnt_q == '0 && !load) |=> flg_q)
    else $error("no flag at underflow");

  assert_single_shot_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!arm_q && !flg_q && !load) |=> !flg_q)
    else $error("one-shot flagged twice");

  assert_reload_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && free_run && cnt_q == '0 && !load) |=> (cnt_q == $past(reload_val)))
    else $error("free-run reload wrong");

  assert_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr && !load && !(run_q && arm_q && cnt_q == '0)) |=> !flg_q)
    else $error("flag not cleared");
endmodule

// File: rtl/itmr_wave.sv
module itmr_wave
  import itmr_pkg::*;
#(
  parameter int BW = BYTE_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ctl_we,
  input  logic [BW-1:0] wdata,
  input  logic          start,
  input  logic          expire,
  input  logic          prog_bit,
  input  logic          prog_dir,
  input  logic          pin_in,
  output logic [BW-1:0] ctl,
  output logic          pin_val,
  output logic          pin_oe,
  output logic          port_rd_bit
);
  logic [BW-1:0] ctl_q, ctl_d;
  logic          wav_q, wav_d;
  logic          mode;

  assign mode = ctl_q[CTL_WAVE];

  always_comb begin
    ctl_d = ctl_we ? wdata : ctl_q;
    wav_d = wav_q;
    if (ctl_we && !wdata[CTL_WAVE]) wav_d = 1'b1;
    else if (start && mode)         wav_d = 1'b0;
    else if (expire && mode)        wav_d = ~wav_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q <= '0;
      wav_q <= 1'b1;
    end else begin
      if (ctl_we) ctl_q <= ctl_d;
      wav_q <= wav_d;
    end
  end

  assign ctl         = ctl_q;
  assign pin_val     = mode ? wav_q : prog_bit;
  assign pin_oe      = mode | prog_dir;
  assign port_rd_bit = mode ? wav_q : (prog_dir ? prog_bit : pin_in);

  assert_start_low_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start && mode && !ctl_we) |=> !wav_q)
    else $error("start did not drive low");

  assert_toggle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire && mode && !start && !ctl_we) |=> (wav_q != $past(wav_q)))
    else $error("expiry did not invert");

  assert_exit_high_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_we && !wdata[CTL_WAVE]) |=> wav_q)
    else $error("wave bit not set high");
endmodule

// File: rtl/itmr_top.sv
module itmr_top
  import itmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  output logic              irq,
  input  logic              prog_bit,
  input  logic              prog_dir,
  input  logic              pin_in,
  output logic              pin_val,
  output logic              pin_oe,
  output logic              port_rd_bit
);
  logic [1:0]        rst_sync_q;
  logic              rst_ni;
  itmr_strobe_t      stb;
  logic [CNT_W-1:0]  cnt, lat, ld_val;
  logic [BYTE_W-1:0] ctl;
  logic              expire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  itmr_decode #(.CW(CNT_W), .BW(BYTE_W)) u_dec (
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .cnt(cnt), .lat(lat), .ctl(ctl), .stb(stb), .rdata(bus_rdata)
  );

  itmr_latch #(.CW(CNT_W), .BW(BYTE_W)) u_lat (
    .clk_i(clk), .rst_ni(rst_ni),
    .lo_we(stb.lat_lo_we), .hi_we(stb.lat_hi_we | stb.start_we),
    .wdata(bus_wdata), .lat(lat), .ld_val(ld_val)
  );

  itmr_count #(.CW(CNT_W)) u_cnt (
    .clk_i(clk), .rst_ni(rst_ni),
    .load(stb.start_we), .ld_val(ld_val), .reload_val(lat),
    .free_run(ctl[CTL_FREE]), .clr(stb.lat_hi_we | stb.cnt_lo_rd),
    .cnt(cnt), .flag(irq), .expire(expire)
  );

  itmr_wave #(.BW(BYTE_W)) u_wav (
    .clk_i(clk), .rst_ni(rst_ni),
    .ctl_we(stb.ctl_we), .wdata(bus_wdata),
    .start(stb.start_we), .expire(expire),
    .prog_bit(prog_bit), .prog_dir(prog_dir), .pin_in(pin_in),
    .ctl(ctl), .pin_val(pin_val), .pin_oe(pin_oe), .port_rd_bit(port_rd_bit)
  );

  assert_lathi_nostart_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    (stb.lat_hi_we && !expire) |=> !irq)
    else $error("latch-high write left flag");
endmodule

// File: tb/sim_itmr_top.sv
module sim_itmr_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       bus_wr, bus_rd;
  logic [2:0] bus_addr;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic       irq, prog_bit, prog_dir, pin_in, pin_val, pin_oe, port_rd_bit;

  int n_chk  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  itmr_top u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .prog_bit(prog_bit), .prog_dir(prog_dir), .pin_in(pin_in),
    .pin_val(pin_val), .pin_oe(pin_oe), .port_rd_bit(port_rd_bit)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R1 irq", irq, 0);
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), d);
      chk("R1 register", d, 0);
    end
    tick(5);
    rd(3'd0, d);
    chk("R1 counter stopped", d, 0);
    chk("R11 pin follows prog", pin_val, 1);
    wr(3'd4, 8'h80);
    chk("R1 wave bit high", pin_val, 1);
    wr(3'd4, 8'h00);
  endtask

  task automatic t_latch_bytes();
    logic [7:0] d;
    wr(3'd0, 8'h34);
    rd(3'd2, d);
    chk("R2 latch low via addr 0", d, 8'h34);
    rd(3'd0, d);
    chk("R2 counter untouched", d, 0);
    wr(3'd2, 8'h05);
    rd(3'd2, d);
    chk("R2 latch low via addr 2", d, 8'h05);
    wr(3'd3, 8'h00);
    rd(3'd3, d);
    chk("R3 latch high stored", d, 0);
    tick(2);
    rd(3'd1, d);
    chk("R3 no start", d, 0);
  endtask

  task automatic t_oneshot();
    logic [7:0] d;
    wr(3'd1, 8'h00);
    rd(3'd0, d);
    chk("R4 counter loaded", d, 8'h05);
    tick(4);
    chk("R5 no early flag", irq, 0);
    tick(1);
    chk("R5 flag at N+1", irq, 1);
    rd(3'd1, d);
    chk("R8 read addr1 keeps flag", irq, 1);
    rd(3'd2, d);
    chk("R8 read addr2 keeps flag", irq, 1);
    rd(3'd3, d);
    chk("R8 read addr3 keeps flag", irq, 1);
    rd(3'd0, d);
    chk("R8 read addr0 clears flag", irq, 0);
    tick(65540);
    chk("R6 single flag across wrap", irq, 0);
  endtask

  task automatic t_lathi_clear();
    logic [7:0] d;
    wr(3'd0, 8'h02);
    wr(3'd1, 8'h00);
    tick(3);
    chk("R5 flag for N=2", irq, 1);
    wr(3'd3, 8'h12);
    chk("R3 latch-high clears flag", irq, 0);
    rd(3'd1, d);
    chk("R3 counter not reloaded", d, 8'hFF);
    rd(3'd3, d);
    chk("R3 latch high readback", d, 8'h12);
  endtask

  task automatic t_freerun();
    logic [7:0] d;
    wr(3'd4, 8'h40);
    wr(3'd0, 8'h03);
    wr(3'd1, 8'h00);
    tick(3);
    chk("R7 no early flag", irq, 0);
    tick(1);
    chk("R7 first flag", irq, 1);
    rd(3'd0, d);
    chk("R7 reloaded from latch", d, 8'h03);
    chk("R8 addr0 read clears", irq, 0);
    tick(3);
    chk("R7 second flag", irq, 1);
    wr(3'd1, 8'hA7);
    chk("R4 start clears flag", irq, 0);
    rd(3'd1, d);
    chk("R4 counter high loaded", d, 8'hA7);
    rd(3'd3, d);
    chk("R4 latch high filled", d, 8'hA7);
    wr(3'd4, 8'h00);
  endtask

  task automatic t_wave();
    wr(3'd4, 8'hC0);
    chk("R11 wave oe", pin_oe, 1);
    chk("R10 wave starts high", pin_val, 1);
    wr(3'd0, 8'h02);
    wr(3'd1, 8'h00);
    chk("R9 start drives low", pin_val, 0);
    chk("R11 port read sees wave bit", port_rd_bit, 0);
    tick(2);
    chk("R9 low before expiry", pin_val, 0);
    tick(1);
    chk("R9 first expiry inverts", pin_val, 1);
    tick(3);
    chk("R9 second expiry inverts", pin_val, 0);
    wr(3'd4, 8'h40);
    chk("R11 exit follows prog bit", pin_val, 1);
    prog_bit = 1'b0;
    #1 chk("R11 prog bit low", pin_val, 0);
    chk("R11 read returns prog bit", port_rd_bit, 0);
    prog_dir = 1'b0;
    pin_in   = 1'b1;
    #1 chk("R11 oe follows direction", pin_oe, 0);
    chk("R11 input read returns pin", port_rd_bit, 1);
    @(negedge clk);
    wr(3'd4, 8'hC0);
    chk("R10 re-entry starts high", pin_val, 1);
    chk("R11 oe forced", pin_oe, 1);
    wr(3'd4, 8'h00);
  endtask

  initial begin
    rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
    prog_bit = 1'b1; prog_dir = 1'b1; pin_in = 1'b0;
    tick(3);
    rst_n = 1'b1;
    tick(3);
    t_reset();
    t_latch_bytes();
    t_oneshot();
    t_lathi_clear();
    t_freerun();
    t_wave();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(4 * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule